// File: doc/BRIEF.md
# Three-format instruction decoder

This block turns one 16-bit instruction word of a small 32-bit processor into the control fields an execute stage needs. The top two bits of the word pick one of three layouts. Words with bit 15 clear use the register layout, with an 8-bit operation code and two 4-bit register indices. Words starting `10` use the immediate layout, with a 2-bit sub-operation, one register index and an 8-bit unsigned constant. Words starting `11` are conditional branches, with a 4-bit condition and a 10-bit signed halfword displacement.

Beside the raw fields the decoder reports several derived items. It gives a one-hot operation class, the register, memory and special-register write enables, and a flag for shifts. It also says whether a 32-bit extension word follows, which makes the instruction 6 bytes long instead of 2. Undefined encodings raise an illegal flag. Such a word is given length 2 and cannot write anything.

Inputs are qualified by a valid strobe. The decoded result is registered and appears one clock later. While the strobe is low the last decode is held. Fetching the extension word, executing the operation and accessing memory belong to other blocks.

Top module: `insn_decoder`

## Requirements
- R1: `out_valid` equals the value `in_valid` had one clock earlier. All other outputs also appear one clock after the word is presented.
- R2: While `in_valid` is low, every decoded field output keeps its previous value.
- R3: `fmt` is 0 when insn[15] is 0, 1 when insn[15:14] is 10 and 2 when insn[15:14] is 11.
- R4: In the register layout, `opcode` = insn[15:8], `rd_idx` = insn[7:4] and `rs_idx` = insn[3:0]. `sub_op`, `cond`, `imm8` and `br_off` are zero.
- R5: In the immediate layout, `sub_op` = insn[13:12], `rd_idx` = `rs_idx` = insn[11:8] and `imm8` = insn[7:0]. `opcode`, `cond` and `br_off` are zero.
- R6: In the branch layout, `cond` = insn[13:10]. `br_off` is insn[9:0] taken as a signed value, doubled and sign-extended to ADDR_W bits. `opcode`, `sub_op`, `rd_idx`, `rs_idx` and `imm8` are zero.
- R7: A register-layout word is legal only when its opcode is in 0x00..0x0E or 0x19..0x39. A branch word is legal only when its condition is 0..9. Every immediate-layout word is legal. `illegal` is the inverse of legality.
- R8: `has_ext` is 1 and `len` is 6 exactly for register opcodes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 and 0x36..0x39. Every other decoded word gives `has_ext` 0 and `len` 2.
- R9: `cls` is one-hot, with bit 0 ALU, bit 1 load, bit 2 store, bit 3 branch, bit 4 call, bit 5 return, bit 6 trap and bit 7 special register. The ALU class covers opcodes 00, 01, 02, 05, 0E, 1B, 20, 26..2F, 31..34 and immediate sub-ops 0 and 1. Load covers 07, 08, 0A, 0C, 1C, 1D, 21, 22, 36 and 38. Store covers 06, 09, 0B, 0D, 1E, 1F, 23, 24, 37 and 39. Branch covers 1A, 25 and every legal branch word. Call covers 03 and 19, and return covers 04. Trap covers 30 and 35, and special register covers immediate sub-ops 2 and 3.
- R10: `reg_we` is set for opcodes 01, 02, 05, 06, 07, 08, 0A, 0C, 1B, 1C, 1D, 20, 21, 22, 26..2F, 31..34, 36 and 38, and for immediate sub-ops 0, 1 and 2. `mem_we` is set for opcodes 03, 06, 09, 0B, 0D, 19, 1E, 1F, 23, 24, 37 and 39. `sreg_we` is set only for immediate sub-op 3.
- R11: `shift_op` is 1 only for register opcodes 0x27, 0x28 and 0x2D, whose shift amount is the low 5 bits of register B.
- R12: An illegal word gives `len` 2, `has_ext` 0, `cls` 0 and all three write enables 0.
- R13: After reset, `out_valid` and every field output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word is present |
| insn | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded result is fresh |
| fmt | output | 2 | Layout: 0 register, 1 immediate, 2 branch |
| opcode | output | 8 | Register-layout operation code |
| sub_op | output | 2 | Immediate-layout sub-operation |
| cond | output | 4 | Branch condition |
| rd_idx | output | 4 | Destination / first register index |
| rs_idx | output | 4 | Source / second register index |
| imm8 | output | 8 | Unsigned 8-bit constant |
| br_off | output | ADDR_W | Signed byte displacement of a branch |
| has_ext | output | 1 | A 32-bit extension word follows |
| len | output | 3 | Instruction length in bytes (2 or 6) |
| cls | output | 8 | One-hot operation class |
| illegal | output | 1 | Undefined encoding |
| reg_we | output | 1 | Operation writes a general register |
| mem_we | output | 1 | Operation writes memory |
| sreg_we | output | 1 | Operation writes a special register |
| shift_op | output | 1 | Operation is a shift (amount masked to 5 bits) |

## Verification
All 65,536 instruction words are applied back to back, one per clock, and every output is compared with values the bench derives from the requirement lists. This sweep covers each layout boundary at bits 15 and 14. It also covers both edges of each legal opcode range (0x0E/0x0F, 0x18/0x19, 0x39/0x3A), the condition edge between 9 and 10, and the displacement sign change between 0x1FF and 0x200. A word held with the strobe low after the sweep shows that the fields freeze rather than follow the input. The reset state is checked before any word is applied.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int CLS_W = 8;

    typedef enum logic [1:0] {
        FMT_REG = 2'd0,
        FMT_IMM = 2'd1,
        FMT_BR  = 2'd2
    } fmt_e;

    localparam logic [CLS_W-1:0] CLS_ALU    = 8'h01;
    localparam logic [CLS_W-1:0] CLS_LOAD   = 8'h02;
    localparam logic [CLS_W-1:0] CLS_STORE  = 8'h04;
    localparam logic [CLS_W-1:0] CLS_BRANCH = 8'h08;
    localparam logic [CLS_W-1:0] CLS_CALL   = 8'h10;
    localparam logic [CLS_W-1:0] CLS_RET    = 8'h20;
    localparam logic [CLS_W-1:0] CLS_TRAP   = 8'h40;
    localparam logic [CLS_W-1:0] CLS_SREG   = 8'h80;

    localparam logic [3:0] COND_LAST = 4'd9;

endpackage

// File: rtl/idec_reg_fmt.sv
module idec_reg_fmt
    import idec_pkg::*;
(
    input  logic [7:0]       opc,
    output logic             legal,
    output logic             ext,
    output logic             reg_we,
    output logic             mem_we,
    output logic             shift,
    output logic [CLS_W-1:0] cls
);

    always_comb begin
        legal  = 1'b1;
        ext    = 1'b0;
        reg_we = 1'b0;
        mem_we = 1'b0;
        cls    = '0;
        case (opc) inside
            8'h00, 8'h0E: cls = CLS_ALU;
            8'h01, 8'h1B, 8'h20: begin
                cls = CLS_ALU; reg_we = 1'b1; ext = 1'b1;
            end
            8'h02, 8'h05, [8'h26:8'h2F], [8'h31:8'h34]: begin
                cls = CLS_ALU; reg_we = 1'b1;
            end
            8'h03: begin cls = CLS_CALL; mem_we = 1'b1; ext = 1'b1; end
            8'h19: begin cls = CLS_CALL; mem_we = 1'b1; end
            8'h04: cls = CLS_RET;
            8'h06: begin cls = CLS_STORE; mem_we = 1'b1; reg_we = 1'b1; end
            8'h07, 8'h0A, 8'h1C, 8'h21: begin
                cls = CLS_LOAD; reg_we = 1'b1;
            end
            8'h08, 8'h0C, 8'h1D, 8'h22, 8'h36, 8'h38: begin
                cls = CLS_LOAD; reg_we = 1'b1; ext = 1'b1;
            end
            8'h09, 8'h0D, 8'h1F, 8'h24, 8'h37, 8'h39: begin
                cls = CLS_STORE; mem_we = 1'b1; ext = 1'b1;
            end
            8'h0B, 8'h1E, 8'h23: begin cls = CLS_STORE; mem_we = 1'b1; end
            8'h1A: begin cls = CLS_BRANCH; ext = 1'b1; end
            8'h25: cls = CLS_BRANCH;
            8'h30: begin cls = CLS_TRAP; ext = 1'b1; end
            8'h35: cls = CLS_TRAP;
            default: legal = 1'b0;
        endcase
        shift = (opc == 8'h27) || (opc == 8'h28) || (opc == 8'h2D);
    end

endmodule

// File: rtl/idec_imm_fmt.sv
module idec_imm_fmt
    import idec_pkg::*;
(
    input  logic [1:0]       sub,
    output logic [CLS_W-1:0] cls,
    output logic             reg_we,
    output logic             sreg_we
);

    always_comb begin
        cls     = CLS_ALU;
        reg_we  = 1'b1;
        sreg_we = 1'b0;
        case (sub)
            2'd2: cls = CLS_SREG;
            2'd3: begin cls = CLS_SREG; reg_we = 1'b0; sreg_we = 1'b1; end
            default: ;
        endcase
    end

endmodule

// File: rtl/idec_br_fmt.sv
module idec_br_fmt
    import idec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [3:0]        cond,
    input  logic [9:0]        disp,
    output logic              legal,
    output logic [ADDR_W-1:0] off
);

    localparam int DISP_W = 10;
    localparam int PAD_W  = ADDR_W - DISP_W - 1;

    assign legal = (cond <= COND_LAST);
    assign off   = {{PAD_W{disp[DISP_W-1]}}, disp, 1'b0};

endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
    import idec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [15:0]       insn,
    output logic              out_valid,
    output logic [1:0]        fmt,
    output logic [7:0]        opcode,
    output logic [1:0]        sub_op,
    output logic [3:0]        cond,
    output logic [3:0]        rd_idx,
    output logic [3:0]        rs_idx,
    output logic [7:0]        imm8,
    output logic [ADDR_W-1:0] br_off,
    output logic              has_ext,
    output logic [2:0]        len,
    output logic [CLS_W-1:0]  cls,
    output logic              illegal,
    output logic              reg_we,
    output logic              mem_we,
    output logic              sreg_we,
    output logic              shift_op
);

    localparam logic [2:0] LEN_SHORT = 3'd2;
    localparam logic [2:0] LEN_LONG  = 3'd6;

    typedef struct packed {
        logic              vld;
        logic [1:0]        fmt;
        logic [7:0]        opc;
        logic [1:0]        sub;
        logic [3:0]        cnd;
        logic [3:0]        rd;
        logic [3:0]        rs;
        logic [7:0]        imm;
        logic [ADDR_W-1:0] off;
        logic              ext;
        logic [2:0]        len;
        logic [CLS_W-1:0]  cls;
        logic              ill;
        logic              rwe;
        logic              mwe;
        logic              swe;
        logic              sh;
    } dec_t;

    dec_t dec_d, dec_q;

    logic             r_legal, r_ext, r_rwe, r_mwe, r_sh;
    logic [CLS_W-1:0] r_cls, i_cls;
    logic             i_rwe, i_swe;
    logic             b_legal;
    logic [ADDR_W-1:0] b_off;

    idec_reg_fmt u_reg (
        .opc    (insn[15:8]),
        .legal  (r_legal),
        .ext    (r_ext),
        .reg_we (r_rwe),
        .mem_we (r_mwe),
        .shift  (r_sh),
        .cls    (r_cls)
    );

    idec_imm_fmt u_imm (
        .sub     (insn[13:12]),
        .cls     (i_cls),
        .reg_we  (i_rwe),
        .sreg_we (i_swe)
    );

    idec_br_fmt #(.ADDR_W(ADDR_W)) u_br (
        .cond  (insn[13:10]),
        .disp  (insn[9:0]),
        .legal (b_legal),
        .off   (b_off)
    );

    always_comb begin
        dec_d     = dec_q;
        dec_d.vld = in_valid;
        if (in_valid) begin
            dec_d     = '0;
            dec_d.vld = 1'b1;
            if (!insn[15]) begin
                dec_d.fmt = FMT_REG;
                dec_d.opc = insn[15:8];
                dec_d.rd  = insn[7:4];
                dec_d.rs  = insn[3:0];
                dec_d.ext = r_ext;
                dec_d.cls = r_cls;
                dec_d.ill = !r_legal;
                dec_d.rwe = r_rwe;
                dec_d.mwe = r_mwe;
                dec_d.sh  = r_sh;
            end else if (!insn[14]) begin
                dec_d.fmt = FMT_IMM;
                dec_d.sub = insn[13:12];
                dec_d.rd  = insn[11:8];
                dec_d.rs  = insn[11:8];
                dec_d.imm = insn[7:0];
                dec_d.cls = i_cls;
                dec_d.rwe = i_rwe;
                dec_d.swe = i_swe;
            end else begin
                dec_d.fmt = FMT_BR;
                dec_d.cnd = insn[13:10];
                dec_d.off = b_off;
                dec_d.cls = b_legal ? CLS_BRANCH : '0;
                dec_d.ill = !b_legal;
            end
            dec_d.len = dec_d.ext ? LEN_LONG : LEN_SHORT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign out_valid = dec_q.vld;
    assign fmt       = dec_q.fmt;
    assign opcode    = dec_q.opc;
    assign sub_op    = dec_q.sub;
    assign cond      = dec_q.cnd;
    assign rd_idx    = dec_q.rd;
    assign rs_idx    = dec_q.rs;
    assign imm8      = dec_q.imm;
    assign br_off    = dec_q.off;
    assign has_ext   = dec_q.ext;
    assign len       = dec_q.len;
    assign cls       = dec_q.cls;
    assign illegal   = dec_q.ill;
    assign reg_we    = dec_q.rwe;
    assign mem_we    = dec_q.mwe;
    assign sreg_we   = dec_q.swe;
    assign shift_op  = dec_q.sh;

endmodule

// File: rtl/idec_checker.sv
module idec_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic [1:0]        fmt,
    input logic [7:0]        opcode,
    input logic [3:0]        rd_idx,
    input logic [ADDR_W-1:0] br_off,
    input logic              has_ext,
    input logic [2:0]        len,
    input logic [7:0]        cls,
    input logic              illegal,
    input logic              reg_we,
    input logic              mem_we,
    input logic              sreg_we,
    input logic              shift_op
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1
    AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R1
    AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(opcode) && $stable(rd_idx) && $stable(cls) && $stable(br_off))); // R2
    AST_EXT_REG_ONLY: assert property (@(posedge clk) disable iff (rst)
        has_ext |-> fmt == 2'd0); // R8
    AST_LEN_VALUES: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (len == 3'd2 || len == 3'd6)); // R8
    AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cls)); // R9
    AST_SREG_IMM_ONLY: assert property (@(posedge clk) disable iff (rst)
        sreg_we |-> fmt == 2'd1); // R10
    AST_SHIFT_IS_ALU: assert property (@(posedge clk) disable iff (rst)
        shift_op |-> cls == 8'h01); // R11
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!reg_we && !mem_we && !sreg_we && !has_ext && len == 3'd2 && cls == 8'h00)); // R12

endmodule

bind insn_decoder idec_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .fmt       (fmt),
    .opcode    (opcode),
    .rd_idx    (rd_idx),
    .br_off    (br_off),
    .has_ext   (has_ext),
    .len       (len),
    .cls       (cls),
    .illegal   (illegal),
    .reg_we    (reg_we),
    .mem_we    (mem_we),
    .sreg_we   (sreg_we),
    .shift_op  (shift_op)
);

// File: tb/insn_decoder_test.sv
module insn_decoder_test;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [15:0]   insn = '0;
    logic          out_valid, has_ext, illegal, reg_we, mem_we, sreg_we, shift_op;
    logic [1:0]    fmt, sub_op;
    logic [7:0]    opcode, imm8, cls;
    logic [3:0]    cond, rd_idx, rs_idx;
    logic [AW-1:0] br_off;
    logic [2:0]    len;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    insn_decoder #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .out_valid(out_valid), .fmt(fmt), .opcode(opcode), .sub_op(sub_op),
        .cond(cond), .rd_idx(rd_idx), .rs_idx(rs_idx), .imm8(imm8),
        .br_off(br_off), .has_ext(has_ext), .len(len), .cls(cls),
        .illegal(illegal), .reg_we(reg_we), .mem_we(mem_we),
        .sreg_we(sreg_we), .shift_op(shift_op)
    );

    // expected values
    logic [1:0]    e_fmt, e_sub;
    logic [7:0]    e_opc, e_imm, e_cls;
    logic [3:0]    e_cnd, e_rd, e_rs;
    logic [AW-1:0] e_off;
    logic          e_ext, e_ill, e_rwe, e_mwe, e_swe, e_sh;
    logic [2:0]    e_len;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s insn=%h actual=%h expected=%h", tag, insn, act, exp);
        end
    endtask

    task automatic calc(input logic [15:0] w);
        int d;
        e_fmt = 0; e_sub = 0; e_opc = 0; e_imm = 0; e_cls = 0; e_cnd = 0;
        e_rd = 0; e_rs = 0; e_off = 0; e_ext = 0; e_ill = 0;
        e_rwe = 0; e_mwe = 0; e_swe = 0; e_sh = 0;
        if (w[15] == 1'b0) begin
            e_opc = w[15:8]; e_rd = w[7:4]; e_rs = w[3:0];
            e_ill = !((e_opc <= 8'h0E) || (e_opc >= 8'h19 && e_opc <= 8'h39));
            e_ext = e_opc inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D, 8'h1A,
                                  8'h1B, 8'h1D, 8'h1F, 8'h20, 8'h22, 8'h24, 8'h30,
                                  [8'h36:8'h39]};
            if (e_opc inside {8'h00, 8'h01, 8'h02, 8'h05, 8'h0E, 8'h1B, 8'h20,
                              [8'h26:8'h2F], [8'h31:8'h34]}) e_cls = 8'h01;
            if (e_opc inside {8'h07, 8'h08, 8'h0A, 8'h0C, 8'h1C, 8'h1D, 8'h21,
                              8'h22, 8'h36, 8'h38}) e_cls = 8'h02;
            if (e_opc inside {8'h06, 8'h09, 8'h0B, 8'h0D, 8'h1E, 8'h1F, 8'h23,
                              8'h24, 8'h37, 8'h39}) e_cls = 8'h04;
            if (e_opc inside {8'h1A, 8'h25}) e_cls = 8'h08;
            if (e_opc inside {8'h03, 8'h19}) e_cls = 8'h10;
            if (e_opc == 8'h04) e_cls = 8'h20;
            if (e_opc inside {8'h30, 8'h35}) e_cls = 8'h40;
            e_rwe = e_opc inside {8'h01, 8'h02, 8'h05, 8'h06, 8'h07, 8'h08, 8'h0A,
                                  8'h0C, 8'h1B, 8'h1C, 8'h1D, 8'h20, 8'h21, 8'h22,
                                  [8'h26:8'h2F], [8'h31:8'h34], 8'h36, 8'h38};
            e_mwe = e_opc inside {8'h03, 8'h06, 8'h09, 8'h0B, 8'h0D, 8'h19, 8'h1E,
                                  8'h1F, 8'h23, 8'h24, 8'h37, 8'h39};
            e_sh  = e_opc inside {8'h27, 8'h28, 8'h2D};
        end else if (w[14] == 1'b0) begin
            e_fmt = 2'd1; e_sub = w[13:12]; e_rd = w[11:8]; e_rs = w[11:8];
            e_imm = w[7:0];
            e_cls = (e_sub < 2) ? 8'h01 : 8'h80;
            e_rwe = (e_sub != 2'd3);
            e_swe = (e_sub == 2'd3);
        end else begin
            e_fmt = 2'd2; e_cnd = w[13:10];
            d = int'(w[9:0]);
            if (d >= 512) d = d - 1024;
            e_off = AW'(d * 2);
            e_ill = (e_cnd > 4'd9);
            e_cls = e_ill ? 8'h00 : 8'h08;
        end
        e_len = e_ext ? 3'd6 : 3'd2;
    endtask

    task automatic check_all();
        string ftag;
        ftag = (e_fmt == 0) ? "R4 fields" : (e_fmt == 1) ? "R5 fields" : "R6 fields";
        chk("R1 out_valid", 64'(out_valid), 64'd1);
        chk("R3 fmt", 64'(fmt), 64'(e_fmt));
        chk(ftag, 64'({opcode, sub_op, cond, rd_idx, rs_idx, imm8}),
                  64'({e_opc, e_sub, e_cnd, e_rd, e_rs, e_imm}));
        chk("R6 br_off", 64'(br_off), 64'(e_off));
        chk("R7 illegal", 64'(illegal), 64'(e_ill));
        chk("R8 ext/len", 64'({has_ext, len}), 64'({e_ext, e_len}));
        chk("R9 cls", 64'(cls), 64'(e_cls));
        chk("R10 write enables", 64'({reg_we, mem_we, sreg_we}), 64'({e_rwe, e_mwe, e_swe}));
        chk("R11 shift_op", 64'(shift_op), 64'(e_sh));
        if (e_ill) begin
            chk("R12 illegal quiet", 64'({has_ext, len, cls, reg_we, mem_we, sreg_we}),
                64'({1'b0, 3'd2, 8'h00, 3'b000}));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R13: reset state, still nothing presented
        chk("R13 reset state", 64'({out_valid, fmt, opcode, sub_op, cond, rd_idx, rs_idx,
                                     imm8, has_ext, len, cls, illegal, reg_we, mem_we,
                                     sreg_we, shift_op}), 64'd0);
        chk("R13 reset br_off", 64'(br_off), 64'd0);
        for (int w = 0; w < 65536; w++) begin
            insn = 16'(w);
            in_valid = 1'b1;
            @(negedge clk);
            calc(16'(w));
            check_all();
        end
        // R1/R2: strobe low, different word, fields must not follow
        in_valid = 1'b0;
        insn = 16'h0527;
        @(negedge clk);
        chk("R1 out_valid low", 64'(out_valid), 64'd0);
        calc(16'hFFFF);
        chk("R2 hold fields", 64'({fmt, opcode, cond, rd_idx, cls, illegal}),
                              64'({e_fmt, e_opc, e_cnd, e_rd, e_cls, e_ill}));
        chk("R2 hold br_off", 64'(br_off), 64'(e_off));
        @(negedge clk);
        chk("R2 hold second cycle", 64'({cond, illegal}), 64'({e_cnd, e_ill}));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule